// File: doc/BRIEF.md
# Page-Aware Reordering Request Scheduler

This block sits in front of a DRAM command sequencer and holds pending read and write requests in a small pool of independent slots. The pool is not a FIFO: any occupied slot may leave first. Each cycle the block offers one request on its dispatch port. It prefers requests whose row is already open in their bank, so accesses to one row go out back to back. A row hit costs only the column latency, while a row miss adds the row-to-column delay and roughly doubles the access time.

The block exports the bank and row of every occupied slot. The logic that tracks open rows, which lies outside this block, answers with one page-hit flag per slot. The scheduler groups hits ahead of misses. Within a class it takes the oldest request, so no request waits forever. It never lets a read and a write to the same address pass each other. Two requests of the same type to one address may still be reordered.

The address splits, from least significant bit upward, into a column field of COL_W bits, then a bank field of BANK_W bits, then a row field of ROW_W bits. Command timing, refresh and the decision to close a row are handled elsewhere.

Top module: `rsq_sched`

## Requirements
- R1: After a synchronous active-low reset, no slot is occupied, `dsp_valid` is 0 and `enq_full` is 0.
- R2: A request offered with `enq_valid` high while `enq_full` is low is stored at the next clock edge in the lowest-numbered free slot, and that bit of `slot_valid` goes high.
- R3: `enq_full` is high exactly when every slot is occupied. A request offered while it is high is dropped, and no slot changes apart from one freed by dispatch.
- R4: `dsp_valid` is high whenever at least one occupied slot is eligible. A slot is freed only at an edge where `dsp_valid` and `dsp_ready` are both high, and only the offered slot is freed.
- R5: If any eligible slot has its `page_hit` bit set, the offered slot is one of those page-hit slots.
- R6: Among the eligible slots of the preferred class (page hits if there are any, otherwise all eligible slots), the one stored earliest is offered.
- R7: A slot is ineligible while an earlier-stored, still-occupied slot holds the same address with the opposite type (read vs write). Two reads to one address, or two writes to one address, do not block each other.
- R8: An enqueue and a dispatch in the same cycle both take effect at that edge.
- R9: `dsp_write` and `dsp_addr` equal the stored type (1 = write) and address of the slot numbered `dsp_slot`. `dsp_bank` and `dsp_row` are that address's bank and row fields. `dsp_hit` equals `page_hit[dsp_slot]`.
- R10: `slot_bank` and `slot_row` carry, for slot k, the bank and row fields at bit offsets k*BANK_W and k*ROW_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | New request offered |
| enq_write | input | 1 | Request type, 1 = write, 0 = read |
| enq_addr | input | ROW_W+BANK_W+COL_W | Request address |
| enq_full | output | 1 | All slots occupied |
| page_hit | input | DEPTH | Per-slot flag: slot's row is open in its bank |
| slot_valid | output | DEPTH | Per-slot occupancy |
| slot_bank | output | DEPTH*BANK_W | Bank field of each slot |
| slot_row | output | DEPTH*ROW_W | Row field of each slot |
| dsp_valid | output | 1 | A request is offered |
| dsp_ready | input | 1 | Downstream takes the offered request |
| dsp_write | output | 1 | Type of offered request |
| dsp_addr | output | ROW_W+BANK_W+COL_W | Address of offered request |
| dsp_bank | output | BANK_W | Bank field of offered request |
| dsp_row | output | ROW_W | Row field of offered request |
| dsp_hit | output | 1 | Offered request is a page hit |
| dsp_slot | output | $clog2(DEPTH) | Slot number of offered request |

## Verification
The hardest case to reach is a younger page-hit request held back by an older opposite-type request to the same address, while other hits and misses compete in the same cycle. A directed sequence stores a write and then two reads to one address and flags only the reads as hits. A long pseudo-random run then draws addresses from a pool of eight values, with random hit flags and random `dsp_ready`, so blocking, release, full-queue drops and same-cycle enqueue plus dispatch occur many times. A reference model in the bench predicts the offered slot from arrival order.

// File: rtl/rsq_pkg.sv
// Package: shared request-type encoding for the reordering scheduler.
// Assumes: a write is encoded as 1 and a read as 0 on every port.
package rsq_pkg;
    typedef enum logic {
        RSQ_READ  = 1'b0,
        RSQ_WRITE = 1'b1
    } rsq_op_e;
endpackage

// File: rtl/rsq_store.sv
// Slot storage: holds type, address and occupancy for each slot, allocates
// the lowest free slot, and keeps a pairwise arrival-order matrix.
// Assumes: at most one enqueue and one free per cycle; the freed slot is
// occupied, so it never equals the slot being allocated.
module rsq_store
    import rsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 9,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               enq_do,
    input  rsq_op_e                            enq_op,
    input  logic [ADDR_W-1:0]                  enq_addr,
    input  logic                               free_do,
    input  logic [IDX_W-1:0]                   free_idx,
    output logic [DEPTH-1:0]                   vld,
    output logic [DEPTH-1:0]                   is_wr,
    output logic [DEPTH-1:0][ADDR_W-1:0]       addr,
    output logic [DEPTH-1:0][DEPTH-1:0]        earlier,
    output logic                               full
);
    logic [IDX_W-1:0] alloc_idx;

    // Find the lowest-numbered free slot.
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && !found) begin
                alloc_idx = IDX_W'(i);
                found     = 1'b1;
            end
        end
    end

    // Queue is full when every slot is occupied.
    assign full = &vld;

    // Update occupancy, payload and the order matrix (earlier[j][i]: j stored before i).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld     <= '0;
            is_wr   <= '0;
            addr    <= '0;
            earlier <= '0;
        end else begin
            if (free_do) begin
                vld[free_idx] <= 1'b0;
            end
            if (enq_do) begin
                vld[alloc_idx]   <= 1'b1;
                is_wr[alloc_idx] <= (enq_op == RSQ_WRITE);
                addr[alloc_idx]  <= enq_addr;
                for (int j = 0; j < DEPTH; j++) begin
                    earlier[alloc_idx][j] <= 1'b0;
                    earlier[j][alloc_idx] <= vld[j] && (IDX_W'(j) != alloc_idx);
                end
            end
        end
    end
endmodule

// File: rtl/rsq_hazard.sv
// Hazard check: marks a slot blocked while an earlier occupied slot holds the
// same address with the opposite type.
// Assumes: the order matrix is a strict order over occupied slots.
module rsq_hazard #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 9
) (
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0]             is_wr,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0][DEPTH-1:0]  earlier,
    output logic [DEPTH-1:0]             blocked
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        // Scan all other slots for an older conflicting access.
        always_comb begin
            blocked[gi] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (vld[j] && earlier[j][gi] && (addr[j] == addr[gi]) &&
                    (is_wr[j] != is_wr[gi])) begin
                    blocked[gi] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsq_pick.sv
// Dispatch selector: forms the eligible set, narrows it to page hits when any
// exist, then takes the earliest-stored member.
// Assumes: earlier[j][i] gives a strict total order over occupied slots.
module rsq_pick #(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0]            blocked,
    input  logic [DEPTH-1:0]            hit,
    input  logic [DEPTH-1:0][DEPTH-1:0] earlier,
    output logic [DEPTH-1:0]            pick,
    output logic                        any,
    output logic [IDX_W-1:0]            pick_idx
);
    logic [DEPTH-1:0] eligible;
    logic [DEPTH-1:0] hit_set;
    logic [DEPTH-1:0] cand;

    // Eligible set and preferred class.
    always_comb begin
        eligible = vld & ~blocked;
        hit_set  = eligible & hit;
        cand     = (|hit_set) ? hit_set : eligible;
        any      = |eligible;
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_age
        // A candidate wins when no other candidate was stored before it.
        always_comb begin
            pick[gi] = cand[gi];
            for (int j = 0; j < DEPTH; j++) begin
                if (cand[j] && earlier[j][gi]) begin
                    pick[gi] = 1'b0;
                end
            end
        end
    end

    // Encode the one-hot winner as a slot number.
    always_comb begin
        pick_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick[i]) begin
                pick_idx = pick_idx | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rsq_sched.sv
// Top: reordering request scheduler. Stores requests in slots, exports each
// slot's bank and row for external open-row lookup, and offers one request
// per cycle on a valid/ready port chosen by page-hit class then age.
// Assumes: address layout {row, bank, column}; page_hit refers to the slots
// as currently occupied; the offered choice may change until accepted.
module rsq_sched
    import rsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    input  logic                      enq_write,
    input  logic [ADDR_W-1:0]         enq_addr,
    output logic                      enq_full,
    input  logic [DEPTH-1:0]          page_hit,
    output logic [DEPTH-1:0]          slot_valid,
    output logic [DEPTH*BANK_W-1:0]   slot_bank,
    output logic [DEPTH*ROW_W-1:0]    slot_row,
    output logic                      dsp_valid,
    input  logic                      dsp_ready,
    output logic                      dsp_write,
    output logic [ADDR_W-1:0]         dsp_addr,
    output logic [BANK_W-1:0]         dsp_bank,
    output logic [ROW_W-1:0]          dsp_row,
    output logic                      dsp_hit,
    output logic [IDX_W-1:0]          dsp_slot
);
    logic [DEPTH-1:0]             vld;
    logic [DEPTH-1:0]             is_wr;
    logic [DEPTH-1:0][ADDR_W-1:0] addr;
    logic [DEPTH-1:0][DEPTH-1:0]  earlier;
    logic [DEPTH-1:0]             blocked;
    logic [DEPTH-1:0]             pick;
    logic                         any;
    logic [IDX_W-1:0]             pick_idx;
    logic                         full;
    logic                         enq_do;
    logic                         free_do;
    rsq_op_e                      enq_op;

    // Accept handshakes at the edges.
    assign enq_do  = enq_valid && !full;
    assign free_do = any && dsp_ready;
    assign enq_op  = enq_write ? RSQ_WRITE : RSQ_READ;

    rsq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq_do   (enq_do),
        .enq_op   (enq_op),
        .enq_addr (enq_addr),
        .free_do  (free_do),
        .free_idx (pick_idx),
        .vld      (vld),
        .is_wr    (is_wr),
        .addr     (addr),
        .earlier  (earlier),
        .full     (full)
    );

    rsq_hazard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_hazard (
        .vld     (vld),
        .is_wr   (is_wr),
        .addr    (addr),
        .earlier (earlier),
        .blocked (blocked)
    );

    rsq_pick #(.DEPTH(DEPTH)) u_pick (
        .vld      (vld),
        .blocked  (blocked),
        .hit      (page_hit),
        .earlier  (earlier),
        .pick     (pick),
        .any      (any),
        .pick_idx (pick_idx)
    );

    // Per-slot bank and row decode for the external open-row lookup.
    for (genvar gk = 0; gk < DEPTH; gk++) begin : g_dec
        assign slot_bank[gk*BANK_W +: BANK_W] = addr[gk][COL_W +: BANK_W];
        assign slot_row[gk*ROW_W +: ROW_W]    = addr[gk][COL_W+BANK_W +: ROW_W];
    end

    // Drive the dispatch port from the selected slot.
    always_comb begin
        dsp_valid = any;
        dsp_slot  = pick_idx;
        dsp_write = is_wr[pick_idx];
        dsp_addr  = addr[pick_idx];
        dsp_bank  = addr[pick_idx][COL_W +: BANK_W];
        dsp_row   = addr[pick_idx][COL_W+BANK_W +: ROW_W];
        dsp_hit   = page_hit[pick_idx];
    end

    assign enq_full   = full;
    assign slot_valid = vld;
endmodule

// File: rtl/rsq_sched_chk.sv
// Checker: temporal properties of the scheduler, bound into every instance.
// Assumes: it sees the hazard vector and one-hot selection of the top.
module rsq_sched_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             enq_full,
    input logic [DEPTH-1:0] page_hit,
    input logic [DEPTH-1:0] slot_valid,
    input logic [DEPTH-1:0] blocked,
    input logic [DEPTH-1:0] pick,
    input logic             dsp_valid,
    input logic             dsp_ready,
    input logic             dsp_hit,
    input logic [IDX_W-1:0] dsp_slot
);
    logic [IDX_W-1:0] slot_q;

    // Remember last cycle's offered slot.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= dsp_slot;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_full && !(dsp_valid && dsp_ready)) |=> (slot_valid == $past(slot_valid)));

    // R4
    hold_unaccepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_ready) |=> slot_valid[slot_q]);

    // R4
    free_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_ready) |=> !slot_valid[slot_q]);

    // R4
    offer_when_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(slot_valid & ~blocked)) |-> dsp_valid);

    // R5
    hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_hit) |-> ((page_hit & slot_valid & ~blocked) == '0));

    // R6
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

    // R7
    no_hazard_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> !blocked[dsp_slot]);
endmodule

bind rsq_sched rsq_sched_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_full   (enq_full),
    .page_hit   (page_hit),
    .slot_valid (slot_valid),
    .blocked    (blocked),
    .pick       (pick),
    .dsp_valid  (dsp_valid),
    .dsp_ready  (dsp_ready),
    .dsp_hit    (dsp_hit),
    .dsp_slot   (dsp_slot)
);

// File: tb/sim_rsq_sched.sv
// Bench: reference model of slot occupancy and arrival order, driven by
// directed sequences and a long pseudo-random sweep.
module sim_rsq_sched;
    localparam int DEPTH  = 8;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic enq_valid, enq_write, enq_full;
    logic [ADDR_W-1:0] enq_addr;
    logic [DEPTH-1:0] page_hit, slot_valid;
    logic [DEPTH*BANK_W-1:0] slot_bank;
    logic [DEPTH*ROW_W-1:0] slot_row;
    logic dsp_valid, dsp_ready, dsp_write, dsp_hit;
    logic [ADDR_W-1:0] dsp_addr;
    logic [BANK_W-1:0] dsp_bank;
    logic [ROW_W-1:0] dsp_row;
    logic [IDX_W-1:0] dsp_slot;

    always #10 clk = ~clk;

    rsq_sched #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_write(enq_write),
        .enq_addr(enq_addr), .enq_full(enq_full), .page_hit(page_hit),
        .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_row(slot_row),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_write(dsp_write),
        .dsp_addr(dsp_addr), .dsp_bank(dsp_bank), .dsp_row(dsp_row),
        .dsp_hit(dsp_hit), .dsp_slot(dsp_slot)
    );

    int errs = 0;
    int chks = 0;
    bit               mv [DEPTH];
    bit               mwr[DEPTH];
    logic [ADDR_W-1:0] ma [DEPTH];
    int               mseq[DEPTH];
    int               seqc = 0;
    logic [15:0]      lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Model prediction of the offered slot per R5, R6, R7.
    task automatic predict(input logic [DEPTH-1:0] hv, output bit ev, output int es);
        bit elig[DEPTH];
        bit anyhit;
        int best;
        anyhit = 0;
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = mv[i];
            for (int j = 0; j < DEPTH; j++)
                if (mv[j] && mseq[j] < mseq[i] && ma[j] == ma[i] && mwr[j] != mwr[i])
                    elig[i] = 0;
            if (elig[i] && hv[i]) anyhit = 1;
        end
        best = -1;
        for (int i = 0; i < DEPTH; i++)
            if (elig[i] && (!anyhit || hv[i]))
                if (best < 0 || mseq[i] < mseq[best]) best = i;
        ev = (best >= 0);
        es = (best >= 0) ? best : 0;
    endtask

    // One cycle: drive, check mid-cycle, update model at the edge.
    task automatic step(input bit ev, input bit ew, input logic [ADDR_W-1:0] ea,
                        input logic [DEPTH-1:0] hv, input bit rdy);
        bit e_v, full_m;
        int e_s, k;
        logic [DEPTH-1:0] mvec;
        enq_valid = ev; enq_write = ew; enq_addr = ea; page_hit = hv; dsp_ready = rdy;
        #5;
        predict(hv, e_v, e_s);
        full_m = 1;
        for (int i = 0; i < DEPTH; i++) begin
            mvec[i] = mv[i];
            if (!mv[i]) full_m = 0;
        end
        check(enq_full == full_m, "R3 full", enq_full, full_m);
        check(slot_valid == mvec, "R2/R8 occupancy", slot_valid, mvec);
        check(dsp_valid == e_v, "R4 valid", dsp_valid, e_v);
        if (e_v) begin
            check(dsp_slot == IDX_W'(e_s), "R5/R6/R7 slot", dsp_slot, e_s);
            check(dsp_write == mwr[e_s] && dsp_addr == ma[e_s], "R9 payload", dsp_addr, ma[e_s]);
            check(dsp_bank == ma[e_s][COL_W +: BANK_W] && dsp_row == ma[e_s][COL_W+BANK_W +: ROW_W],
                  "R9 fields", {dsp_row, dsp_bank}, ma[e_s][ADDR_W-1:COL_W]);
            check(dsp_hit == hv[e_s], "R9 hit", dsp_hit, hv[e_s]);
        end
        for (int i = 0; i < DEPTH; i++)
            if (mv[i])
                check(slot_bank[i*BANK_W +: BANK_W] == ma[i][COL_W +: BANK_W] &&
                      slot_row[i*ROW_W +: ROW_W] == ma[i][COL_W+BANK_W +: ROW_W],
                      "R10 slot fields", slot_row[i*ROW_W +: ROW_W], ma[i][COL_W+BANK_W +: ROW_W]);
        @(posedge clk);
        k = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) k = i;
        if (e_v && rdy) mv[e_s] = 0;
        if (ev && !full_m && k >= 0) begin
            mv[k] = 1; mwr[k] = ew; ma[k] = ea; mseq[k] = seqc; seqc++;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; enq_valid = 0; enq_write = 0; enq_addr = '0; page_hit = '0; dsp_ready = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < DEPTH; i++) mv[i] = 0;
        #5;
        check(dsp_valid == 0 && enq_full == 0, "R1 outputs", {dsp_valid, enq_full}, 0);
        check(slot_valid == '0, "R1 occupancy", slot_valid, 0);
        @(negedge clk);
    endtask

    task automatic drain();
        for (int n = 0; n < 3 * DEPTH; n++) step(0, 0, '0, '0, 1);
    endtask

    initial begin
        #(20 * 200000);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        do_reset();
        // R2, R3: fill all slots, then offer one more while full.
        for (int n = 0; n < DEPTH; n++) step(1, n[0], ADDR_W'(n * 16 + 3), '0, 0);
        step(1, 1, 9'h1FF, '0, 0);
        step(1, 0, 9'h1FE, 8'h00, 0);
        // R5, R6: hits on slots 5 and 7 go first, oldest hit first.
        step(0, 0, '0, 8'hA0, 1);
        step(0, 0, '0, 8'h80, 1);
        // R8: accept and enqueue in the same cycle.
        step(1, 1, 9'h055, 8'h00, 1);
        drain();
        // R7: write then two reads to one address; reads flagged as hits.
        step(1, 1, 9'h0AA, '0, 0);
        step(1, 0, 9'h0AA, '0, 0);
        step(1, 0, 9'h0AA, '0, 0);
        step(1, 0, 9'h011, '0, 0);
        step(0, 0, '0, 8'b0000_0110, 0);
        step(0, 0, '0, 8'b0000_0110, 1);
        step(0, 0, '0, 8'b0000_0100, 1);
        drain();
        // R7: two writes to one address are not ordered against each other.
        step(1, 1, 9'h033, '0, 0);
        step(1, 1, 9'h033, '0, 0);
        step(0, 0, '0, 8'b0000_0010, 1);
        drain();
        // Sweep: small address pool, random hits and ready.
        for (int n = 0; n < 6000; n++) begin
            logic [15:0] a, b;
            lfsr = nxt(lfsr); a = lfsr;
            lfsr = nxt(lfsr); b = lfsr;
            step(a[0] | a[1], a[2], ADDR_W'({a[5], a[4], 1'b0, a[3]}) << 3,
                 b[7:0] ^ a[15:8], b[9] | b[10]);
        end
        do_reset();
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule